// File: doc/BRIEF.md
# PWM-Synchronised Sample Strobe Controller

This block decides when a rotor-position detector may take a sample of its phase-voltage inputs. It divides the system clock by a selectable power of two and turns each division tick into a one-cycle sample strobe. A tick becomes a strobe only while sampling is active and the selected gating condition holds. The gating condition can be the PWM output being high, the lower-side switches conducting, or no condition at all. After each rising edge of PWM, a programmable number of ticks is thrown away, so that switching noise from a transistor that has just turned on is never sampled.

Sampling is switched on by a software start pulse or by a start trigger from a timer, and the timer trigger has its own enable. Stopping works differently. A stop request from software, or from a second timer that has its own enable, does not end sampling at once. It arms a pending stop, and sampling halts only when the downstream match logic reports a position detection. A status output shows whether sampling is running. Nothing happens while the global enable is low, and clearing that enable returns every internal counter and flag to idle.

Top module: `psamp_ctrl`

## Requirements
- R1: After synchronous reset, `sample_stb` and `sampling_active` are both 0.
- R2: While `sampling_active` is 1 in a mode whose gating condition holds, strobes recur every 2, 4, 8 or 16 clock cycles for `cfg_div` codes 0, 1, 2 and 3. The first strobe comes one full period after the cycle in which sampling became active.
- R3: Gating by `cfg_mode`: code 0 passes ticks only while `pwm_in` is 1, code 1 passes every tick, code 2 passes ticks only while `lower_on` is 1, and code 3 behaves as code 1.
- R4: In modes 0 and 2, each rising edge of `pwm_in` (seen while enabled) loads a blanking count from `cfg_blank`. Each division tick while the count is non-zero is suppressed and lowers the count by one, and a tick in the rising-edge cycle itself is also suppressed. A value of 0 gives no blanking. A later rising edge reloads the count.
- R5: In modes 1 and 3, `cfg_blank` and PWM edges have no effect on the strobe pattern.
- R6: A `sw_start` pulse always starts sampling. A `tmr_start` pulse starts sampling only when `cfg_tmr_start_en` is 1. `sampling_active` rises in the cycle after the start pulse.
- R7: A `sw_stop` pulse, or a `tmr_stop` pulse while `cfg_tmr_stop_en` is 1, arms a pending stop and leaves sampling running. `sampling_active` falls in the cycle after the first `det_event` at or after the stop request. A `det_event` with no stop pending has no effect.
- R8: A start pulse in the same cycle as a stop request or a `det_event` wins: sampling is active afterwards and any pending stop is cancelled.
- R9: While `cfg_enable` is 0, starts are ignored and no strobe is produced. Clearing `cfg_enable` returns the active flag, the pending stop, the divider and the blanking count to idle in the next cycle.
- R10: `sample_stb` is a registered pulse one cycle wide. It is high only in a cycle after one in which sampling was active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Global enable for the whole function |
| cfg_div | input | 2 | Sample period code: 2, 4, 8 or 16 clocks |
| cfg_mode | input | 2 | Gating mode code (see R3) |
| cfg_blank | input | 4 | Blanking length in division ticks after a PWM rising edge |
| cfg_tmr_start_en | input | 1 | Enables the timer start trigger |
| cfg_tmr_stop_en | input | 1 | Enables the timer stop trigger |
| pwm_in | input | 1 | PWM output state |
| lower_on | input | 1 | Lower-side phases conducting |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Software stop pulse |
| tmr_start | input | 1 | Start trigger from a timer |
| tmr_stop | input | 1 | Stop trigger from a second timer |
| det_event | input | 1 | Position detection reported by the match logic |
| sample_stb | output | 1 | One-cycle sample strobe |
| sampling_active | output | 1 | Sampling is currently running |

## Verification
The bench times the blanking window from a known divider phase. A design that applied blanking to the wrong number of ticks, or failed to reload the count on a second PWM rising edge, would give a strobe count that differs from the expected value. It tests the deferred stop on both stop sources. A design that halted on the stop request itself, or that accepted a disabled timer trigger, would clear the status too early. It also drives start together with a stop request and with a detection, and drops the enable in mid-run. These catch the wrong priority, a pending stop that survives a start, and an active flag that outlives the enable.

// File: rtl/psamp_pkg.sv
package psamp_pkg;

    typedef enum logic [1:0] {
        GATE_PWM      = 2'd0,
        GATE_FREE     = 2'd1,
        GATE_LOWER    = 2'd2,
        GATE_FREE_ALT = 2'd3
    } gate_mode_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic det;
    } run_req_t;

    function automatic logic mode_is_synced(gate_mode_e m);
        return (m == GATE_PWM) || (m == GATE_LOWER);
    endfunction

    function automatic logic gate_pass(gate_mode_e m, logic pwm, logic low, logic blank_busy);
        logic ok;
        case (m)
            GATE_PWM:   ok = pwm & ~blank_busy;
            GATE_LOWER: ok = low & ~blank_busy;
            default:    ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/psamp_prescale.sv
module psamp_prescale #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int PRE_W = 2 ** DIV_W;

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] last;

    // terminal count has div_sel+1 low ones: 1, 3, 7, 15 ...
    always_comb begin
        last = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i <= int'(div_sel)) last[i] = 1'b1;
        end
    end

    assign tick = run && (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // R9: divider is parked at zero whenever it is not running
    a_r9_prescale_idle: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0));

    // R10: a tick never lasts two cycles
    a_r10_tick_single: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/psamp_blank.sv
module psamp_blank #(
    parameter int BLANK_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               pwm_in,
    input  logic               tick,
    input  logic [BLANK_W-1:0] blank_len,
    output logic               busy
);
    logic               pwm_q;
    logic               rise;
    logic [BLANK_W-1:0] bcnt_q;

    assign rise = pwm_in & ~pwm_q;
    // look ahead so a tick in the rise cycle is already blanked
    assign busy = (bcnt_q != '0) | (rise & (blank_len != '0));

    always_ff @(posedge clk) begin
        if (rst) pwm_q <= 1'b0;
        else     pwm_q <= pwm_in;
    end

    always_ff @(posedge clk) begin
        if (rst || !en)                bcnt_q <= '0;
        else if (rise)                 bcnt_q <= blank_len;
        else if (tick && bcnt_q != '0) bcnt_q <= bcnt_q - 1'b1;
    end

    // R4: a rising edge with a non-zero length opens a blanking window
    a_r4_blank_load: assert property (@(posedge clk) disable iff (rst)
        (en && rise && blank_len != '0) |=> busy);

    // R9: disabled block holds no blanking state
    a_r9_blank_clear: assert property (@(posedge clk) disable iff (rst)
        !en |=> (bcnt_q == '0));

endmodule

// File: rtl/psamp_runctl.sv
module psamp_runctl
    import psamp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  run_req_t req,
    output logic     active
);
    logic active_q;
    logic pend_q;

    assign active = active_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            active_q <= 1'b0;
            pend_q   <= 1'b0;
        end else if (req.start) begin
            active_q <= 1'b1;
            pend_q   <= 1'b0;
        end else if (active_q && (req.stop || pend_q) && req.det) begin
            active_q <= 1'b0;
            pend_q   <= 1'b0;
        end else if (active_q && req.stop) begin
            pend_q   <= 1'b1;
        end
    end

    // R8: start wins over anything in the same cycle
    a_r8_start_wins: assert property (@(posedge clk) disable iff (rst)
        (en && req.start) |=> active_q);

    // R7: without a detection, a running sampler keeps running
    a_r7_hold_until_det: assert property (@(posedge clk) disable iff (rst)
        (en && active_q && !req.det) |=> active_q);

    // R7: a detection with no stop outstanding changes nothing
    a_r7_det_alone: assert property (@(posedge clk) disable iff (rst)
        (en && active_q && req.det && !req.stop && !pend_q) |=> active_q);

    // R9: dropping the enable idles the run state
    a_r9_enable_clears: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!active_q && !pend_q));

endmodule

// File: rtl/psamp_ctrl.sv
module psamp_ctrl
    import psamp_pkg::*;
#(
    parameter int DIV_W   = 2,
    parameter int BLANK_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_enable,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [1:0]         cfg_mode,
    input  logic [BLANK_W-1:0] cfg_blank,
    input  logic               cfg_tmr_start_en,
    input  logic               cfg_tmr_stop_en,
    input  logic               pwm_in,
    input  logic               lower_on,
    input  logic               sw_start,
    input  logic               sw_stop,
    input  logic               tmr_start,
    input  logic               tmr_stop,
    input  logic               det_event,
    output logic               sample_stb,
    output logic               sampling_active
);
    gate_mode_e mode;
    run_req_t   req;
    logic       active;
    logic       tick;
    logic       blank_raw;
    logic       blank_busy;
    logic       gate_ok;
    logic       stb_q;

    assign mode      = gate_mode_e'(cfg_mode);
    assign req.start = sw_start | (tmr_start & cfg_tmr_start_en);
    assign req.stop  = sw_stop  | (tmr_stop  & cfg_tmr_stop_en);
    assign req.det   = det_event;

    psamp_runctl i_run (
        .clk    (clk),
        .rst    (rst),
        .en     (cfg_enable),
        .req    (req),
        .active (active)
    );

    psamp_prescale #(.DIV_W(DIV_W)) i_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (cfg_enable & active),
        .div_sel (cfg_div),
        .tick    (tick)
    );

    psamp_blank #(.BLANK_W(BLANK_W)) i_blank (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg_enable),
        .pwm_in    (pwm_in),
        .tick      (tick),
        .blank_len (cfg_blank),
        .busy      (blank_raw)
    );

    // blanking only matters in the PWM-synchronised modes
    assign blank_busy = blank_raw & mode_is_synced(mode);
    assign gate_ok    = gate_pass(mode, pwm_in, lower_on, blank_busy);

    always_ff @(posedge clk) begin
        if (rst) stb_q <= 1'b0;
        else     stb_q <= cfg_enable & tick & gate_ok;
    end

    assign sample_stb      = stb_q;
    assign sampling_active = active;

    // R10: strobe follows a cycle of active sampling
    a_r10_stb_needs_active: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> $past(active));

    // R10: strobe is one cycle wide
    a_r10_stb_single: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb);

    // R9: no strobe after a disabled cycle
    a_r9_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> !sample_stb);

    // R3: in PWM-gated mode a strobe needs PWM high in the tick cycle
    a_r3_pwm_gate: assert property (@(posedge clk) disable iff (rst)
        (sample_stb && $past(cfg_mode) == 2'd0) |-> $past(pwm_in));

    // R3: in lower-phase mode a strobe needs conduction in the tick cycle
    a_r3_lower_gate: assert property (@(posedge clk) disable iff (rst)
        (sample_stb && $past(cfg_mode) == 2'd2) |-> $past(lower_on));

endmodule

// File: tb/test_psamp_ctrl.sv
module test_psamp_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_enable = 1'b0;
    logic [1:0] cfg_div = 2'd0;
    logic [1:0] cfg_mode = 2'd1;
    logic [3:0] cfg_blank = 4'd0;
    logic       cfg_tmr_start_en = 1'b0;
    logic       cfg_tmr_stop_en = 1'b0;
    logic       pwm_in = 1'b0;
    logic       lower_on = 1'b0;
    logic       sw_start = 1'b0;
    logic       sw_stop = 1'b0;
    logic       tmr_start = 1'b0;
    logic       tmr_stop = 1'b0;
    logic       det_event = 1'b0;
    logic       sample_stb;
    logic       sampling_active;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    psamp_ctrl i_psamp_ctrl (
        .clk              (clk),
        .rst              (rst),
        .cfg_enable       (cfg_enable),
        .cfg_div          (cfg_div),
        .cfg_mode         (cfg_mode),
        .cfg_blank        (cfg_blank),
        .cfg_tmr_start_en (cfg_tmr_start_en),
        .cfg_tmr_stop_en  (cfg_tmr_stop_en),
        .pwm_in           (pwm_in),
        .lower_on         (lower_on),
        .sw_start         (sw_start),
        .sw_stop          (sw_stop),
        .tmr_start        (tmr_start),
        .tmr_stop         (tmr_stop),
        .det_event        (det_event),
        .sample_stb       (sample_stb),
        .sampling_active  (sampling_active)
    );

    // mode, div, pwm, lower, expected strobes over 64 cycles
    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] div;
        logic       pwm;
        logic       lower;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 2'd0, 1'b0, 1'b0, 8'd32},
        '{2'd1, 2'd1, 1'b0, 1'b0, 8'd16},
        '{2'd1, 2'd2, 1'b0, 1'b0, 8'd8},
        '{2'd1, 2'd3, 1'b0, 1'b0, 8'd4},
        '{2'd0, 2'd1, 1'b1, 1'b0, 8'd16},
        '{2'd0, 2'd1, 1'b0, 1'b1, 8'd0},
        '{2'd2, 2'd0, 1'b0, 1'b1, 8'd32},
        '{2'd2, 2'd0, 1'b1, 1'b0, 8'd0},
        '{2'd3, 2'd2, 1'b0, 1'b0, 8'd8}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic count_stb(input int n, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            step();
            if (sample_stb) c++;
        end
    endtask

    task automatic restart(input logic [1:0] mode, input logic [1:0] div);
        cfg_enable = 1'b0;
        cfg_mode   = mode;
        cfg_div    = div;
        step();
        step();
        cfg_enable = 1'b1;
        step();
        sw_start = 1'b1;
        step();
        sw_start = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int c;
        repeat (3) step();
        check("R1 stb in reset", int'(sample_stb), 0);
        check("R1 active in reset", int'(sampling_active), 0);
        rst = 1'b0;
        step();
        check("R1 stb after reset", int'(sample_stb), 0);
        check("R1 active after reset", int'(sampling_active), 0);

        // R2 R3 table
        for (int v = 0; v < NV; v++) begin
            cfg_enable = 1'b0;
            pwm_in     = VECS[v].pwm;
            lower_on   = VECS[v].lower;
            cfg_blank  = 4'd0;
            restart(VECS[v].mode, VECS[v].div);
            count_stb(64, c);
            check($sformatf("R2/R3 vector %0d strobe count", v), c, int'(VECS[v].exp));
        end

        // R4 blanking in PWM mode, divider /2, length 3
        cfg_enable = 1'b0;
        pwm_in     = 1'b0;
        lower_on   = 1'b0;
        cfg_mode   = 2'd0;
        cfg_div    = 2'd0;
        cfg_blank  = 4'd3;
        step();
        cfg_enable = 1'b1;
        step();
        pwm_in = 1'b1;
        step();
        step();
        sw_start = 1'b1;
        step();
        sw_start = 1'b0;
        count_stb(64, c);
        check("R4 first window after rise", c, 29);
        pwm_in = 1'b0;
        count_stb(2, c);
        check("R3 no strobe with pwm low", c, 0);
        pwm_in = 1'b1;
        count_stb(16, c);
        check("R4 reload on second rise", c, 5);

        // R4 blanking in lower-phase mode
        cfg_enable = 1'b0;
        pwm_in     = 1'b0;
        lower_on   = 1'b1;
        cfg_mode   = 2'd2;
        step();
        cfg_enable = 1'b1;
        step();
        pwm_in = 1'b1;
        step();
        step();
        sw_start = 1'b1;
        step();
        sw_start = 1'b0;
        count_stb(64, c);
        check("R4 lower mode blanked ticks", c, 29);

        // R5 blanking ignored in free-running mode
        lower_on  = 1'b0;
        pwm_in    = 1'b0;
        cfg_blank = 4'd15;
        restart(2'd1, 2'd0);
        count_stb(2, c);
        pwm_in = 1'b1;
        count_stb(16, c);
        check("R5 free mode ignores blanking", c, 8);
        cfg_blank = 4'd0;

        // R6 timer start enable
        cfg_enable = 1'b0;
        step();
        cfg_enable = 1'b1;
        cfg_tmr_start_en = 1'b0;
        tmr_start = 1'b1;
        step();
        tmr_start = 1'b0;
        check("R6 disabled timer start ignored", int'(sampling_active), 0);
        cfg_tmr_start_en = 1'b1;
        tmr_start = 1'b1;
        step();
        tmr_start = 1'b0;
        check("R6 enabled timer start", int'(sampling_active), 1);
        cfg_tmr_start_en = 1'b0;

        // R7 deferred software stop
        restart(2'd1, 2'd0);
        count_stb(8, c);
        sw_stop = 1'b1;
        step();
        sw_stop = 1'b0;
        check("R7 active after stop request", int'(sampling_active), 1);
        count_stb(16, c);
        check("R7 strobes continue while stop pending", c, 8);
        det_event = 1'b1;
        step();
        det_event = 1'b0;
        check("R7 halt on detection", int'(sampling_active), 0);
        count_stb(16, c);
        check("R7 no strobes after halt", c, 0);

        // R7 detection with nothing pending, timer stop enable
        restart(2'd1, 2'd0);
        det_event = 1'b1;
        step();
        det_event = 1'b0;
        check("R7 detection alone ignored", int'(sampling_active), 1);
        cfg_tmr_stop_en = 1'b0;
        tmr_stop = 1'b1;
        step();
        tmr_stop = 1'b0;
        det_event = 1'b1;
        step();
        det_event = 1'b0;
        check("R7 disabled timer stop ignored", int'(sampling_active), 1);
        cfg_tmr_stop_en = 1'b1;
        tmr_stop = 1'b1;
        step();
        tmr_stop = 1'b0;
        check("R7 timer stop deferred", int'(sampling_active), 1);
        det_event = 1'b1;
        step();
        det_event = 1'b0;
        check("R7 timer stop halts on detection", int'(sampling_active), 0);
        cfg_tmr_stop_en = 1'b0;

        // R8 start priority
        sw_start = 1'b1;
        sw_stop  = 1'b1;
        step();
        sw_start = 1'b0;
        sw_stop  = 1'b0;
        check("R8 start beats stop", int'(sampling_active), 1);
        det_event = 1'b1;
        step();
        det_event = 1'b0;
        check("R8 no stop armed by simultaneous pulse", int'(sampling_active), 1);
        sw_stop = 1'b1;
        step();
        sw_stop   = 1'b0;
        sw_start  = 1'b1;
        det_event = 1'b1;
        step();
        sw_start  = 1'b0;
        det_event = 1'b0;
        check("R8 start beats detection", int'(sampling_active), 1);
        det_event = 1'b1;
        step();
        det_event = 1'b0;
        check("R8 start cancels pending stop", int'(sampling_active), 1);

        // R9 enable
        cfg_enable = 1'b0;
        step();
        check("R9 active cleared by enable", int'(sampling_active), 0);
        sw_start = 1'b1;
        step();
        sw_start = 1'b0;
        check("R9 start ignored when disabled", int'(sampling_active), 0);
        count_stb(16, c);
        check("R9 no strobes when disabled", c, 0);
        cfg_enable = 1'b1;
        step();
        check("R9 stays idle on re-enable", int'(sampling_active), 0);
        sw_start = 1'b1;
        step();
        sw_start = 1'b0;
        count_stb(16, c);
        check("R10 strobe count after clean restart", c, 8);

        finish_run();
    end

endmodule